// File: doc/BRIEF.md
# UART Channel Mode FIFO Router

This block sits between a host register port, a byte-wide receive path coming from a serial deserializer and a byte-wide transmit path going to a serializer. It holds one receive FIFO and one transmit FIFO. A two-bit channel mode chooses where each byte goes. Received bytes can go to the host, be echoed back out, or both. Host bytes can go to the line or loop straight back to the host.

A small control word enables and disables each direction and flushes either FIFO. The block raises an overrun event when a byte arrives for a full FIFO. It also fires a receive-timeout event once the receive side has been idle for four character times. The status flags (full, empty, at-or-above-trigger) are derived every cycle from the fill levels and the trigger inputs. Baud timing, bit serialization and interrupt masking belong to neighbouring blocks.

Top module: `uart_mode_router`

## Requirements
- R1: `mode_sel` selects the routing: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. A serial byte (`ser_rx_valid`) enters the RX FIFO in modes 0 and 1, and enters the TX FIFO in modes 1 and 3. In mode 2 it is dropped.
- R2: A host data write (`host_wr`) enters the TX FIFO in mode 0 and the RX FIFO in mode 2. In modes 1 and 3 it is dropped.
- R3: A byte is pushed into the RX FIFO only while control bit 2 (RX on) is 1 and bit 3 (RX off) is 0. A byte is pushed into the TX FIFO only while bit 4 (TX on) is 1 and bit 5 (TX off) is 0.
- R4: When the RX path is not live, the bytes already in the RX FIFO are kept. A host read then returns 0 and removes nothing.
- R5: The control word is 6 bits wide and resets to 0x28 (both paths off). A control write stores bits 5:2. Writing 1 to bit 0 empties the RX FIFO and writing 1 to bit 1 empties the TX FIFO. Bits 1:0 always read back as 0.
- R6: A push request to a full RX FIFO or a full TX FIFO drops the byte and pulses `ev_overrun` in that same cycle.
- R7: For each FIFO, full means count equals the depth (64), empty means count equals zero, and trigger means count is greater than or equal to the trigger input.
- R8: Each FIFO holds 64 bytes and returns them in arrival order.
- R9: Every byte accepted into the RX FIFO restarts an idle window of 4×`CHAR_CLKS` cycles. If no further byte is accepted, `ev_rx_timeout` is high for one cycle exactly that many cycles after the accepting cycle, but only while `timeout_val` is nonzero.
- R10: `host_rdata` shows the RX FIFO head during the read cycle. When the RX FIFO is empty it is 0.
- R11: `ser_tx_valid` is high whenever the TX FIFO is not empty, with the head on `ser_tx_data`. The byte is removed in a cycle where `ser_tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Channel mode |
| rx_trig_lvl | input | 7 | RX trigger level |
| tx_trig_lvl | input | 7 | TX trigger level |
| timeout_val | input | 8 | Timeout enable value (nonzero arms the timeout) |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 6 | Control word write data |
| ctrl_q | output | 6 | Control word readback |
| host_wr | input | 1 | Host data write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host data read strobe |
| host_rdata | output | 8 | Host read byte |
| ser_rx_valid | input | 1 | Received byte strobe |
| ser_rx_data | input | 8 | Received byte |
| ser_tx_valid | output | 1 | Transmit byte available |
| ser_tx_data | output | 8 | Transmit byte |
| ser_tx_ready | input | 1 | Serializer takes the byte |
| rx_full | output | 1 | RX FIFO full |
| rx_empty | output | 1 | RX FIFO empty |
| rx_trig | output | 1 | RX count at or above trigger |
| tx_full | output | 1 | TX FIFO full |
| tx_empty | output | 1 | TX FIFO empty |
| tx_trig | output | 1 | TX count at or above trigger |
| ev_overrun | output | 1 | Overrun event pulse |
| ev_rx_timeout | output | 1 | Receive idle timeout pulse |

## Verification
The overrun cases are the hardest to reach from the ports. Reaching them takes exactly 64 accepted bytes in one FIFO while its consumer is held off. For TX, that means keeping `ser_tx_ready` low for the whole fill, so the 65th push meets a full FIFO. The bench fills each FIFO this way, steps the fill level across the trigger input, forces the 65th push, and then drains the FIFO to confirm that nothing was lost or reordered. The timeout is checked by counting cycles from a single accepted byte to the pulse, and then repeated with the timeout value at zero.

// File: rtl/uart_rt_pkg.sv
package uart_rt_pkg;

  typedef enum logic [1:0] {
    CH_NORMAL    = 2'd0,
    CH_ECHO      = 2'd1,
    CH_LOCAL_LB  = 2'd2,
    CH_REMOTE_LB = 2'd3
  } ch_mode_e;

  localparam int CTRL_W      = 6;
  localparam int CB_RX_FLUSH = 0;
  localparam int CB_TX_FLUSH = 1;
  localparam int CB_RX_ON    = 2;
  localparam int CB_RX_OFF   = 3;
  localparam int CB_TX_ON    = 4;
  localparam int CB_TX_OFF   = 5;
  localparam logic [CTRL_W-1:0] CTRL_RST = 6'h28;

  function automatic logic path_live(input logic on_bit, input logic off_bit);
    return on_bit & ~off_bit;
  endfunction

  function automatic logic lvl_full(input int cnt, input int depth);
    return cnt == depth;
  endfunction

  function automatic logic lvl_empty(input int cnt);
    return cnt == 0;
  endfunction

  function automatic logic lvl_trig(input int cnt, input int trig);
    return cnt >= trig;
  endfunction

endpackage

// File: rtl/rt_fifo.sv
module rt_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          push_ok
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

endmodule

// File: rtl/rt_idle_timer.sv
module rt_idle_timer #(
  parameter int WIN = 40,
  localparam int TW = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic allow,
  output logic fire
);

  logic [TW-1:0] remain;
  logic          armed;

  assign fire = armed && (remain == '0) && allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      armed  <= 1'b0;
    end else if (kick) begin
      remain <= TW'(WIN - 1);
      armed  <= 1'b1;
    end else if (armed) begin
      if (remain == '0) armed  <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
  import uart_rt_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int CHAR_CLKS = 10,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int WIN      = 4 * CHAR_CLKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [CW-1:0]     rx_trig_lvl,
  input  logic [CW-1:0]     tx_trig_lvl,
  input  logic [7:0]        timeout_val,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  input  logic              host_rd,
  output logic [7:0]        host_rdata,
  input  logic              ser_rx_valid,
  input  logic [7:0]        ser_rx_data,
  output logic              ser_tx_valid,
  output logic [7:0]        ser_tx_data,
  input  logic              ser_tx_ready,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_trig,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_trig,
  output logic              ev_overrun,
  output logic              ev_rx_timeout
);

  ch_mode_e      mode;
  logic          rx_on, tx_on;
  logic          rx_flush, tx_flush;
  logic          ser_to_rx, ser_to_tx, host_to_rx, host_to_tx;
  logic          rx_push_req, tx_push_req;
  logic [7:0]    rx_push_data, tx_push_data;
  logic          rx_pop, tx_pop;
  logic          rx_accept, tx_accept;
  logic [7:0]    rx_head, tx_head;
  logic [CW-1:0] rx_cnt, tx_cnt;

  assign mode = ch_mode_e'(mode_sel);

  // control word: flush bits act on the write and are never stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_wr) ctrl_q <= {ctrl_wdata[CTRL_W-1:2], 2'b00};
  end

  assign rx_on    = path_live(ctrl_q[CB_RX_ON], ctrl_q[CB_RX_OFF]);
  assign tx_on    = path_live(ctrl_q[CB_TX_ON], ctrl_q[CB_TX_OFF]);
  assign rx_flush = ctrl_wr && ctrl_wdata[CB_RX_FLUSH];
  assign tx_flush = ctrl_wr && ctrl_wdata[CB_TX_FLUSH];

  // routing matrix
  assign ser_to_rx  = (mode == CH_NORMAL) || (mode == CH_ECHO);
  assign ser_to_tx  = (mode == CH_ECHO)   || (mode == CH_REMOTE_LB);
  assign host_to_rx = (mode == CH_LOCAL_LB);
  assign host_to_tx = (mode == CH_NORMAL);

  assign rx_push_req  = rx_on && ((ser_rx_valid && ser_to_rx) || (host_wr && host_to_rx));
  assign rx_push_data = host_to_rx ? host_wdata : ser_rx_data;
  assign tx_push_req  = tx_on && ((ser_rx_valid && ser_to_tx) || (host_wr && host_to_tx));
  assign tx_push_data = host_to_tx ? host_wdata : ser_rx_data;

  assign rx_pop = host_rd && rx_on && !rx_empty;
  assign tx_pop = ser_tx_ready && !tx_empty;

  rt_fifo #(.DEPTH(DEPTH), .DW(8)) i_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push_req), .push_data(rx_push_data), .pop(rx_pop),
    .head(rx_head), .count(rx_cnt), .push_ok(rx_accept)
  );

  rt_fifo #(.DEPTH(DEPTH), .DW(8)) i_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push_req), .push_data(tx_push_data), .pop(tx_pop),
    .head(tx_head), .count(tx_cnt), .push_ok(tx_accept)
  );

  rt_idle_timer #(.WIN(WIN)) i_idle (
    .clk(clk), .rst_n(rst_n), .kick(rx_accept && !rx_flush),
    .allow(timeout_val != 8'd0), .fire(ev_rx_timeout)
  );

  // live status flags
  assign rx_full  = lvl_full(int'(rx_cnt), DEPTH);
  assign rx_empty = lvl_empty(int'(rx_cnt));
  assign rx_trig  = lvl_trig(int'(rx_cnt), int'(rx_trig_lvl));
  assign tx_full  = lvl_full(int'(tx_cnt), DEPTH);
  assign tx_empty = lvl_empty(int'(tx_cnt));
  assign tx_trig  = lvl_trig(int'(tx_cnt), int'(tx_trig_lvl));

  assign ev_overrun = (rx_push_req && !rx_accept) || (tx_push_req && !tx_accept);

  assign host_rdata   = rx_pop ? rx_head : 8'd0;
  assign ser_tx_valid = !tx_empty;
  assign ser_tx_data  = tx_head;

endmodule

// File: rtl/uart_mode_router_chk.sv
module uart_mode_router_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_wr,
  input logic [5:0]    ctrl_wdata,
  input logic [5:0]    ctrl_q,
  input logic          rx_push_req,
  input logic          tx_push_req,
  input logic          rx_full,
  input logic          tx_full,
  input logic          rx_empty,
  input logic          ev_overrun,
  input logic          ev_rx_timeout,
  input logic          rx_accept,
  input logic          rx_on,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          host_rd,
  input logic [7:0]    host_rdata
);

  // R6
  ovr_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_req && rx_full |-> ev_overrun);

  // R6
  ovr_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_req && tx_full |-> ev_overrun);

  // R5
  flush_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && ctrl_wdata[0] |=> rx_empty && (ctrl_q[1:0] == 2'b00));

  // R5
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q[5:2] == $past(ctrl_wdata[5:2]));

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on && !(ctrl_wr && ctrl_wdata[0]) |=> rx_cnt == $past(rx_cnt));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_cnt) <= DEPTH) && (int'(tx_cnt) <= DEPTH));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && rx_empty |-> host_rdata == 8'd0);

  // R9
  tmo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_timeout |-> !$past(rx_accept));

endmodule

bind uart_mode_router uart_mode_router_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
  .ctrl_q(ctrl_q), .rx_push_req(rx_push_req), .tx_push_req(tx_push_req),
  .rx_full(rx_full), .tx_full(tx_full), .rx_empty(rx_empty),
  .ev_overrun(ev_overrun), .ev_rx_timeout(ev_rx_timeout),
  .rx_accept(rx_accept), .rx_on(rx_on), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .host_rd(host_rd), .host_rdata(host_rdata)
);

// File: tb/test_uart_mode_router.sv
module test_uart_mode_router;

  localparam int DEPTH = 64;
  localparam int WIN   = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [6:0] rx_trig_lvl = 7'd32, tx_trig_lvl = 7'd32;
  logic [7:0] timeout_val = 8'd0;
  logic       ctrl_wr = 1'b0;
  logic [5:0] ctrl_wdata = '0, ctrl_q;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       ser_rx_valid = 1'b0, ser_tx_ready = 1'b0, ser_tx_valid;
  logic [7:0] ser_rx_data = '0, ser_tx_data;
  logic       rx_full, rx_empty, rx_trig, tx_full, tx_empty, tx_trig;
  logic       ev_overrun, ev_rx_timeout;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_mode_router i_uart_mode_router (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .rx_trig_lvl(rx_trig_lvl), .tx_trig_lvl(tx_trig_lvl),
    .timeout_val(timeout_val), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .ser_rx_valid(ser_rx_valid),
    .ser_rx_data(ser_rx_data), .ser_tx_valid(ser_tx_valid),
    .ser_tx_data(ser_tx_data), .ser_tx_ready(ser_tx_ready),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_trig(rx_trig),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_trig(tx_trig),
    .ev_overrun(ev_overrun), .ev_rx_timeout(ev_rx_timeout)
  );

  // {mode[1:0], from_serial, lands_rx, lands_tx}
  localparam logic [4:0] ROUTE_TBL [8] = '{
    {2'd0, 1'b1, 1'b1, 1'b0}, {2'd0, 1'b0, 1'b0, 1'b1},
    {2'd1, 1'b1, 1'b1, 1'b1}, {2'd1, 1'b0, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b0}, {2'd2, 1'b0, 1'b1, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b1}, {2'd3, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ctrl(input logic [5:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v; cyc(); ctrl_wr = 1'b0;
  endtask

  task automatic ser_byte(input logic [7:0] b);
    ser_rx_valid = 1'b1; ser_rx_data = b; cyc(); ser_rx_valid = 1'b0;
  endtask

  task automatic host_byte(input logic [7:0] b);
    host_wr = 1'b1; host_wdata = b; cyc(); host_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    #1;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R5 reset state
    chk(ctrl_q == 6'h28, "R5 reset ctrl", ctrl_q, 6'h28);
    chk(rx_empty && tx_empty && !rx_full && !ser_tx_valid, "R7 reset flags",
        {rx_empty, tx_empty, rx_full, ser_tx_valid}, 4'b1100);

    // R1 R2 routing table walk
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      d = 8'hA0 + 8'(i);
      ser_tx_ready = 1'b0;
      ctrl(6'h17);
      mode_sel = ROUTE_TBL[i][4:3];
      if (ROUTE_TBL[i][2]) ser_byte(d); else host_byte(d);
      chk(rx_empty == !ROUTE_TBL[i][1], $sformatf("R1 R2 rx route v%0d", i), rx_empty, !ROUTE_TBL[i][1]);
      chk(ser_tx_valid == ROUTE_TBL[i][0], $sformatf("R1 R2 tx route v%0d", i), ser_tx_valid, ROUTE_TBL[i][0]);
      if (ROUTE_TBL[i][1]) begin
        host_rd = 1'b1; #1;
        chk(host_rdata == d, $sformatf("R10 rx data v%0d", i), host_rdata, d);
        cyc(); host_rd = 1'b0;
      end
      if (ROUTE_TBL[i][0])
        chk(ser_tx_data == d, $sformatf("R11 tx data v%0d", i), ser_tx_data, d);
    end

    // R5 flush bits
    ctrl(6'h17);
    chk(rx_empty && tx_empty && ctrl_q == 6'h14, "R5 flush", ctrl_q, 6'h14);

    // R3 gating: RX on and off both set, TX on and off both set
    mode_sel = 2'd0;
    ctrl(6'h3C);
    ser_byte(8'h11);
    host_byte(8'h22);
    chk(rx_empty, "R3 rx gated", rx_empty, 1);
    chk(!ser_tx_valid, "R3 tx gated", ser_tx_valid, 0);

    // R4 disable keeps contents
    ctrl(6'h14);
    ser_byte(8'h31); ser_byte(8'h32);
    ctrl(6'h1C);
    host_rd = 1'b1; #1;
    chk(host_rdata == 8'h00, "R4 read while off", host_rdata, 0);
    cyc(); host_rd = 1'b0;
    chk(!rx_empty, "R4 kept", rx_empty, 0);
    ctrl(6'h14);
    host_rd = 1'b1; #1;
    chk(host_rdata == 8'h31, "R4 first byte kept", host_rdata, 8'h31);
    cyc(); #1;
    chk(host_rdata == 8'h32, "R8 second byte", host_rdata, 8'h32);
    cyc(); #1;
    // R10 empty read
    chk(host_rdata == 8'h00 && rx_empty, "R10 empty read", host_rdata, 0);
    cyc(); host_rd = 1'b0;

    // R7 R6 R8 RX fill
    ctrl(6'h17);
    for (int k = 1; k <= DEPTH; k++) begin
      ser_byte(8'(k));
      if (k == 31) chk(!rx_trig, "R7 rx trig below", rx_trig, 0);
      if (k == 32) chk(rx_trig, "R7 rx trig at", rx_trig, 1);
      if (k == 63) chk(!rx_full, "R7 rx not full", rx_full, 0);
    end
    chk(rx_full, "R7 rx full", rx_full, 1);
    ser_rx_valid = 1'b1; ser_rx_data = 8'hEE; #1;
    chk(ev_overrun, "R6 rx overrun", ev_overrun, 1);
    cyc(); ser_rx_valid = 1'b0;
    host_rd = 1'b1;
    n = 0;
    for (int k = 1; k <= DEPTH; k++) begin
      #1;
      if (host_rdata != 8'(k)) n++;
      cyc();
    end
    host_rd = 1'b0;
    chk(n == 0 && rx_empty, "R8 rx order", n, 0);

    // R6 R11 TX fill and drain
    ser_tx_ready = 1'b0;
    for (int k = 0; k < DEPTH; k++) host_byte(8'(k + 100));
    chk(tx_full && tx_trig, "R7 tx full", tx_full, 1);
    host_wr = 1'b1; host_wdata = 8'h55; #1;
    chk(ev_overrun, "R6 tx overrun", ev_overrun, 1);
    cyc(); host_wr = 1'b0;
    ser_tx_ready = 1'b1;
    n = 0;
    for (int k = 0; k < DEPTH; k++) begin
      #1;
      if (!ser_tx_valid || ser_tx_data != 8'(k + 100)) n++;
      cyc();
    end
    ser_tx_ready = 1'b0;
    chk(n == 0 && tx_empty, "R11 tx drain order", n, 0);

    // R9 timeout window
    timeout_val = 8'd5;
    repeat (WIN + 5) cyc();
    ser_byte(8'h77);
    n = 1;
    while (!ev_rx_timeout && n < 200) begin cyc(); n++; end
    chk(n == WIN, "R9 timeout delay", n, WIN);
    timeout_val = 8'd0;
    ser_byte(8'h78);
    n = 0;
    for (int k = 0; k < WIN + 10; k++) begin
      if (ev_rx_timeout) n++;
      cyc();
    end
    chk(n == 0, "R9 timeout off", n, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule